// File: doc/BRIEF.md
# Sequential Masked Pattern Trigger

This block watches a bus of monitored signals and raises a trigger once a programmed chain of one, two or three pattern matches has been seen in strict order. Each of the three stages holds its own compare pattern and its own don't-care mask. A compare ignores every channel whose mask bit is set. All patterns and masks are loaded together in one cycle from wide parallel configuration buses.

Software or a capture controller loads the configuration and chooses the number of active stages. It then pulses `arm`. From the cycle after the pulse the block looks only for the first stage. Each match moves the search on to the next stage, and the match of the last active stage sets `trigger`. `trigger` stays high until the next arm. `busy` is high while a sequence is in progress.

Top module: `seq_pattern_trigger`

## Requirements
- R1: A stage matches a sample when every monitor channel i whose mask bit i is 0 equals bit i of that stage's pattern. Bit i of the pattern and of the mask belongs to monitor channel i.
- R2: A mask bit of 1 removes its channel from the compare, so any value on that channel still matches.
- R3: With `stageCount` = 1, `trigger` rises on the clock edge after the first sample that matches stage 1. Stages 2 and 3 have no effect.
- R4: With `stageCount` = 2, the block triggers only on a stage 2 match that follows a stage 1 match. A stage 2 match seen earlier is ignored, and stage 3 has no effect.
- R5: With `stageCount` = 3, the matches must occur in the order stage 1, stage 2, stage 3 before `trigger` rises.
- R6: A stage is evaluated no earlier than the cycle after the previous stage matched, so a single sample never satisfies two stages.
- R7: A `stageCount` of 0 acts as 1. The count is captured in the arm cycle, and later changes to the input have no effect until the next arm.
- R8: In a cycle with `arm` high, no sample is compared. On the following cycle the sequence restarts at stage 1 with `busy` = 1 and `trigger` = 0.
- R9: Once set, `trigger` stays at 1 and `busy` stays at 0 until the next arm, whatever the monitor carries.
- R10: After reset, and before the first arm, `trigger` and `busy` are 0 and no stage advances.
- R11: A cycle with `cfgLoad` = 1 loads all three patterns and masks. Stage s takes bits [s*WIDTH +: WIDTH] of `cfgPattern` and `cfgMask`, with stage 1 at s = 0. The new values are used from the next cycle on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| arm | input | 1 | Restart the sequence at stage 1 and capture the stage count |
| cfgLoad | input | 1 | Load all stage patterns and masks |
| cfgPattern | input | 3*WIDTH | Packed stage patterns, stage 1 in the low slice |
| cfgMask | input | 3*WIDTH | Packed don't-care masks, 1 = ignore channel |
| stageCount | input | 2 | Number of active stages (0 acts as 1) |
| monitor | input | WIDTH | Monitored channels, default 36 |
| trigger | output | 1 | High from the final match until the next arm |
| busy | output | 1 | Armed and still waiting for the sequence |

## Verification
The assertions assume that `arm` is the only way out of the idle and fired states, and that `rst` is a clean synchronous level. They place no limit on how often the monitor or the configuration changes. The stimulus drives every input away from the clock edge. It pulses `arm` for single cycles and also holds it high for several cycles. It reloads the configuration both while a sequence is running and while the block is idle, so the loading rule of R11 is exercised in both states. The random phase mostly sets mask bits so that matches are common, and it changes `stageCount` after arming to exercise the capture rule.

// File: rtl/pst_pkg.sv
package pst_pkg;
  localparam int NUM_STAGES = 3;
  localparam int IDX_W = (NUM_STAGES > 1) ? $clog2(NUM_STAGES) : 1;
  localparam int CNT_W = $clog2(NUM_STAGES + 1);

  typedef logic [NUM_STAGES-1:0] stage_vec_t;

  // strobes from sequencing control to the compare datapath
  typedef struct packed {
    stage_vec_t evalStage;   // one-hot: which stage may match this cycle
  } pst_strobe_t;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_RUN   = 2'd1,
    ST_FIRED = 2'd2
  } seq_state_t;
endpackage

// File: rtl/pst_datapath.sv
module pst_datapath
  import pst_pkg::*;
#(
  parameter int WIDTH = 36,
  localparam int BUS_W = NUM_STAGES * WIDTH
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cfgLoad,
  input  logic [BUS_W-1:0] cfgPattern,
  input  logic [BUS_W-1:0] cfgMask,
  input  logic [WIDTH-1:0] monitor,
  input  pst_strobe_t      strobe,
  output logic             stageHit
);
  stage_vec_t matchVec;

  for (genvar s = 0; s < NUM_STAGES; s++) begin : g_stage
    logic [WIDTH-1:0] patReg;
    logic [WIDTH-1:0] maskReg;

    always_ff @(posedge clk) begin
      if (rst) begin
        patReg  <= '0;
        maskReg <= '0;
      end else if (cfgLoad) begin
        patReg  <= cfgPattern[s*WIDTH +: WIDTH];
        maskReg <= cfgMask[s*WIDTH +: WIDTH];
      end
    end

    // channels whose mask bit is set drop out of the compare
    assign matchVec[s] = ~|((monitor ^ patReg) & ~maskReg);
  end

  assign stageHit = |(matchVec & strobe.evalStage);
endmodule

// File: rtl/pst_control.sv
module pst_control
  import pst_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             arm,
  input  logic [CNT_W-1:0] stageCount,
  input  logic             stageHit,
  output pst_strobe_t      strobe,
  output logic             trigger,
  output logic             busy
);
  seq_state_t       state;
  logic [IDX_W-1:0] stageIdx;
  logic [IDX_W-1:0] lastIdx;
  logic [IDX_W-1:0] armLast;

  // zero acts as one, anything beyond the stage count saturates
  always_comb begin
    if (stageCount == '0)
      armLast = '0;
    else if (int'(stageCount) > NUM_STAGES)
      armLast = IDX_W'(NUM_STAGES - 1);
    else
      armLast = IDX_W'(int'(stageCount) - 1);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_IDLE;
      stageIdx <= '0;
      lastIdx  <= '0;
    end else if (arm) begin
      state    <= ST_RUN;
      stageIdx <= '0;
      lastIdx  <= armLast;
    end else if (state == ST_RUN && stageHit) begin
      if (stageIdx == lastIdx)
        state <= ST_FIRED;
      else
        stageIdx <= stageIdx + 1'b1;
    end
  end

  always_comb begin
    strobe.evalStage = '0;
    if (state == ST_RUN && !arm)
      strobe.evalStage[stageIdx] = 1'b1;
  end

  assign trigger = (state == ST_FIRED);
  assign busy    = (state == ST_RUN);
endmodule

// File: rtl/seq_pattern_trigger.sv
module seq_pattern_trigger
  import pst_pkg::*;
#(
  parameter int WIDTH = 36,
  localparam int BUS_W = NUM_STAGES * WIDTH
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             arm,
  input  logic             cfgLoad,
  input  logic [BUS_W-1:0] cfgPattern,
  input  logic [BUS_W-1:0] cfgMask,
  input  logic [CNT_W-1:0] stageCount,
  input  logic [WIDTH-1:0] monitor,
  output logic             trigger,
  output logic             busy
);
  pst_strobe_t strobe;
  logic        stageHit;

  pst_datapath #(.WIDTH(WIDTH)) u_dp (
    .clk       (clk),
    .rst       (rst),
    .cfgLoad   (cfgLoad),
    .cfgPattern(cfgPattern),
    .cfgMask   (cfgMask),
    .monitor   (monitor),
    .strobe    (strobe),
    .stageHit  (stageHit)
  );

  pst_control u_ctl (
    .clk       (clk),
    .rst       (rst),
    .arm       (arm),
    .stageCount(stageCount),
    .stageHit  (stageHit),
    .strobe    (strobe),
    .trigger   (trigger),
    .busy      (busy)
  );
endmodule

// File: rtl/pst_checker.sv
module pst_checker (
  input logic clk,
  input logic rst,
  input logic arm,
  input logic trigger,
  input logic busy
);
  // R10: reset leaves the block idle and untriggered
  a_r10_reset_idle: assert property (@(posedge clk)
    rst |=> (!trigger && !busy));

  // R10: without an arm, an idle block never starts or fires
  a_r10_idle_stays: assert property (@(posedge clk) disable iff (rst)
    (!busy && !trigger && !arm) |=> (!busy && !trigger));

  // R8: an arm restarts the sequence
  a_r8_arm_restarts: assert property (@(posedge clk) disable iff (rst)
    arm |=> (busy && !trigger));

  // R9: a fired trigger holds until the next arm
  a_r9_trigger_holds: assert property (@(posedge clk) disable iff (rst)
    (trigger && !arm) |=> (trigger && !busy));

  // R9: trigger and busy are never both high
  a_r9_exclusive: assert property (@(posedge clk) disable iff (rst)
    !(trigger && busy));

  // R6: trigger only rises out of a running sequence without a fresh arm
  a_r6_rise_from_run: assert property (@(posedge clk) disable iff (rst)
    $rose(trigger) |-> ($past(busy) && !$past(arm)));
endmodule

bind seq_pattern_trigger pst_checker u_chk (
  .clk    (clk),
  .rst    (rst),
  .arm    (arm),
  .trigger(trigger),
  .busy   (busy)
);

// File: tb/seq_pattern_trigger_bench.sv
module seq_pattern_trigger_bench;
  localparam int W = 36;
  localparam int NS = 3;

  logic            clk = 1'b0;
  logic            rst, arm, cfgLoad;
  logic [NS*W-1:0] cfgPattern, cfgMask;
  logic [1:0]      stageCount;
  logic [W-1:0]    monitor;
  logic            trigger, busy;

  int checks = 0;
  int errors = 0;
  string curReq = "R10";

  // reference model state
  logic [W-1:0] mPat [NS];
  logic [W-1:0] mMask[NS];
  int mState = 0;          // 0 idle, 1 run, 2 fired
  int mIdx = 0;
  int mLast = 0;

  always #4 clk = ~clk;    // 125 MHz

  seq_pattern_trigger u_seq_pattern_trigger (
    .clk(clk), .rst(rst), .arm(arm), .cfgLoad(cfgLoad),
    .cfgPattern(cfgPattern), .cfgMask(cfgMask), .stageCount(stageCount),
    .monitor(monitor), .trigger(trigger), .busy(busy)
  );

  task automatic check(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%b expected=%b at %0t", req, act, exp, $time);
    end
  endtask

  // advance one clock: update the model from the current inputs, then compare
  task automatic step();
    logic hit;
    if (rst) begin
      mState = 0; mIdx = 0; mLast = 0;
      for (int s = 0; s < NS; s++) begin mPat[s] = '0; mMask[s] = '0; end
    end else begin
      hit = (mState == 1) &&
            (((monitor ^ mPat[mIdx]) & ~mMask[mIdx]) == '0);
      if (arm) begin
        mState = 1; mIdx = 0;
        mLast = (stageCount == 0) ? 0 : int'(stageCount) - 1;
      end else if (hit) begin
        if (mIdx == mLast) mState = 2;
        else mIdx++;
      end
      if (cfgLoad)
        for (int s = 0; s < NS; s++) begin
          mPat[s]  = cfgPattern[s*W +: W];
          mMask[s] = cfgMask[s*W +: W];
        end
    end
    @(posedge clk);
    #1;
    check({curReq, " trigger"}, trigger, mState == 2);
    check({curReq, " busy"}, busy, mState == 1);
  endtask

  task automatic loadCfg(input logic [W-1:0] p0, p1, p2, m0, m1, m2);
    cfgPattern = {p2, p1, p0};
    cfgMask    = {m2, m1, m0};
    cfgLoad = 1'b1;
    step();
    cfgLoad = 1'b0;
  endtask

  task automatic doArm(input logic [1:0] cnt);
    stageCount = cnt;
    arm = 1'b1;
    step();
    arm = 1'b0;
  endtask

  task automatic show(input logic [W-1:0] v, input int n);
    monitor = v;
    for (int i = 0; i < n; i++) step();
  endtask

  localparam logic [W-1:0] PA = 36'hA_1234_5678;
  localparam logic [W-1:0] PB = 36'h5_9ABC_DEF0;
  localparam logic [W-1:0] PC = 36'hF_0F0F_0F0F;
  localparam logic [W-1:0] QUIET = 36'h0_0000_0001;

  initial begin : watchdog
    #(8 * 100000);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst = 1'b1; arm = 1'b0; cfgLoad = 1'b0; cfgPattern = '0; cfgMask = '0;
    stageCount = 2'd1; monitor = '0;
    step(); step();
    rst = 1'b0;
    curReq = "R10";
    check("R10 reset trigger", trigger, 1'b0);
    check("R10 reset busy", busy, 1'b0);

    curReq = "R11";
    loadCfg(PA, PB, PC, '0, '0, '0);
    curReq = "R10";
    show(PA, 3);
    check("R10 no advance before arm", trigger, 1'b0);

    // R1/R2/R3: one stage, with a masked channel that differs
    curReq = "R2";
    loadCfg(PA, PB, PC, 36'h8_0000_0001, '0, '0);
    doArm(2'd1);
    show(PA ^ 36'h0_0000_0100, 2);
    check("R1 unmasked mismatch no trigger", trigger, 1'b0);
    show(PA ^ 36'h8_0000_0001, 1);
    check("R2 masked differences still match", trigger, 1'b1);
    check("R3 single stage fired", busy, 1'b0);

    // R9: trigger holds whatever the monitor does
    curReq = "R9";
    show(QUIET, 3);
    show(PB, 2);
    check("R9 trigger held", trigger, 1'b1);

    // R4: stage 2 before stage 1 is ignored
    curReq = "R4";
    loadCfg(PA, PB, PC, '0, '0, '0);
    doArm(2'd2);
    show(PB, 2);
    check("R4 stage 2 first ignored", trigger, 1'b0);
    show(PA, 1); show(QUIET, 1); show(PC, 1);
    check("R4 stage 3 has no effect", trigger, 1'b0);
    show(PB, 1);
    check("R4 two-stage order fires", trigger, 1'b1);

    // R5: wrong order then right order
    curReq = "R5";
    doArm(2'd3);
    show(PA, 1); show(PC, 1);
    check("R5 stage 3 early no trigger", trigger, 1'b0);
    show(PB, 1);
    check("R5 after stage 2 still waiting", busy, 1'b1);
    show(PC, 1);
    check("R5 three-stage order fires", trigger, 1'b1);

    // R6: identical stages need two distinct samples
    curReq = "R6";
    loadCfg(PA, PA, PA, '0, '0, '0);
    doArm(2'd2);
    show(PA, 1); show(QUIET, 1);
    check("R6 single sample one stage", trigger, 1'b0);
    show(PA, 2);
    check("R6 two samples fire", trigger, 1'b1);

    // R7: count 0 acts as 1; count captured at arm
    curReq = "R7";
    loadCfg(PA, PB, PC, '0, '0, '0);
    doArm(2'd0);
    stageCount = 2'd3;
    show(PA, 1);
    check("R7 zero count acts as one", trigger, 1'b1);
    doArm(2'd2);
    stageCount = 2'd1;
    show(PA, 1);
    check("R7 count change after arm ignored", trigger, 1'b0);
    show(PB, 1);
    check("R7 captured count used", trigger, 1'b1);

    // R8: no compare during arm; held arm keeps restarting
    curReq = "R8";
    monitor = PA;
    doArm(2'd1);
    check("R8 arm cycle not compared", trigger, 1'b0);
    check("R8 busy after arm", busy, 1'b1);
    step();
    check("R8 match after arm fires", trigger, 1'b1);
    arm = 1'b1; stageCount = 2'd1;
    step(); step(); step();
    arm = 1'b0;
    check("R8 held arm no fire", trigger, 1'b0);

    // R11: reload while running takes effect next cycle
    curReq = "R11";
    doArm(2'd1);
    monitor = PC;
    loadCfg(PC, PB, PA, '0, '0, '0);
    check("R11 old pattern in load cycle", trigger, 1'b0);
    step();
    check("R11 new pattern used", trigger, 1'b1);

    // random phase with many don't-care bits
    curReq = "R1";
    for (int n = 0; n < 3000; n++) begin
      if ((n % 200) == 0)
        loadCfg(36'($urandom_range(0, 15)), 36'($urandom_range(0, 15)),
                36'($urandom_range(0, 15)), ~36'hF, ~36'h7, ~36'hB);
      if ($urandom_range(0, 29) == 0) doArm(2'($urandom_range(0, 3)));
      stageCount = 2'($urandom_range(0, 3));
      monitor = {32'($urandom), 4'($urandom_range(0, 15))};
      step();
    end

    rst = 1'b1; step(); rst = 1'b0;
    curReq = "R10";
    check("R10 reset after run", trigger, 1'b0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule